// File: doc/BRIEF.md
# Preset-Selected Dual Clock Divider

This block takes one fast reference clock and derives two independent divided clocks from it. A small table of eight presets is fixed at elaboration through a parameter. Each preset gives, for each of the two outputs, an enable flag and an 8-bit divide ratio. A 3-bit select input picks the preset that is in force. Every output runs at a 50% duty cycle: it stays high for ratio/2 reference cycles and then low for ratio/2 cycles.

The select input may change at any time. It is brought into the reference domain through two flops, and each output takes up its new ratio only when its current period ends. This means no shortened high or low phase ever reaches a downstream consumer. A preset field that is disabled, odd, or outside 4..254 silences its output, which is then held low. An active-high enable input controls the per-output drive-enable signals, which stand in for high-impedance drivers. When enable is low, both clocks are forced low. When enable returns, both dividers restart in phase. Before the select synchronizer has captured the pins, the select reads as all ones, which models pins that are pulled up.

Top module: `preset_dual_divider`

## Requirements
- R1: While reset is asserted, both divided clocks and both drive-enable outputs are 0.
- R2: The select input is a binary preset index, with bit 2 as the most significant bit. For a valid field, the output period equals that preset's ratio in reference cycles. Output 0 uses field 0 of the preset and output 1 uses field 1.
- R3: Each valid output is high for exactly ratio/2 reference cycles and then low for exactly ratio/2 reference cycles.
- R4: A field is invalid if its enable flag is 0, if its ratio is odd, or if its ratio is below 4 or above 254. An invalid field holds its output at 0 while that output's drive-enable stays 1.
- R5: If enable is low at a rising reference edge, both clocks and both drive-enables are 0 after that edge, and they stay 0 while enable remains low.
- R6: At the first rising edge with enable high again, both outputs with valid fields go high on that same edge, and both drive-enables return to 1.
- R7: A change of select takes effect only at a period boundary. Across the change, every high or low phase has the old or the new half length, each high phase equals the low phase that follows it, and no old-length phase appears after a new-length one.
- R8: Out of reset, the preset with index 3'b111 is in force until the synchronized select takes over. The first high phase of each output therefore has preset 7's half length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Fast reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| outEnableIn | input | 1 | Active-high output enable |
| presetSel | input | 3 | Preset index, asynchronous to refClk |
| divClk | output | 2 | Divided clocks, bit 0 is output 0 |
| divOe | output | 2 | Per-output drive enable (0 = high impedance) |

## Verification
The bench steps through all eight select values in turn. For each value it measures complete high and low phases on both outputs and compares them with half of the ratio it works out from its own copy of the table. The default table mixes several fault cases on purpose: a cleared enable flag, an odd ratio, a ratio below the minimum, and both the largest and the smallest legal ratios. This separates a faulty validity screen or a faulty half-length computation from a correct one. A select change from preset 7 to preset 0 swaps the half lengths of the two outputs, from 4 to 5 on one and from 5 to 4 on the other. The recorded phase sequence on each output would then expose a runt phase or a reload in mid-period. The enable sweep checks that both outputs go low and that they restart together. The startup run with the select held at 0 shows whether the all-ones default governs the first period.

// File: rtl/pdd_pkg.sv
package pdd_pkg;
  localparam int RATIO_W     = 8;
  localparam int SEL_W       = 3;
  localparam int NUM_OUT     = 2;
  localparam int NUM_PRESETS = 1 << SEL_W;
  localparam int HALF_W      = RATIO_W - 1;
  localparam int MIN_RATIO   = 4;
  localparam int MAX_RATIO   = 254;

  // One output's stored setting inside a preset
  typedef struct packed {
    logic               en;
    logic [RATIO_W-1:0] ratio;
  } presetField_t;

  typedef presetField_t [NUM_OUT-1:0] preset_t;
  typedef preset_t [NUM_PRESETS-1:0]  presetTable_t;

  // Screened configuration handed from control to a divider
  typedef struct packed {
    logic              valid;
    logic [HALF_W-1:0] half;
  } chanCfg_t;

  // Strobes from control to the datapath
  typedef struct packed {
    logic                     halt;
    chanCfg_t [NUM_OUT-1:0]   cfg;
  } ctrlStrobe_t;

  localparam presetTable_t DEFAULT_PRESETS = '{
    7: '{1: '{en: 1'b1, ratio: 8'd10},  0: '{en: 1'b1, ratio: 8'd8}},
    6: '{1: '{en: 1'b1, ratio: 8'd14},  0: '{en: 1'b1, ratio: 8'd255}},
    5: '{1: '{en: 1'b0, ratio: 8'd16},  0: '{en: 1'b0, ratio: 8'd16}},
    4: '{1: '{en: 1'b1, ratio: 8'd4},   0: '{en: 1'b1, ratio: 8'd254}},
    3: '{1: '{en: 1'b1, ratio: 8'd254}, 0: '{en: 1'b1, ratio: 8'd2}},
    2: '{1: '{en: 1'b1, ratio: 8'd9},   0: '{en: 1'b1, ratio: 8'd6}},
    1: '{1: '{en: 1'b1, ratio: 8'd12},  0: '{en: 1'b0, ratio: 8'd20}},
    0: '{1: '{en: 1'b1, ratio: 8'd8},   0: '{en: 1'b1, ratio: 8'd10}}
  };

  // Validity screen: enabled, even, inside the legal range
  function automatic chanCfg_t screenField(presetField_t f);
    chanCfg_t c;
    logic ok;
    ok = f.en && !f.ratio[0] &&
         (f.ratio >= RATIO_W'(MIN_RATIO)) &&
         (f.ratio <= RATIO_W'(MAX_RATIO));
    c.valid = ok;
    c.half  = ok ? f.ratio[RATIO_W-1:1] : '0;
    return c;
  endfunction
endpackage

// File: rtl/pdd_ctrl.sv
module pdd_ctrl
  import pdd_pkg::*;
#(
  parameter presetTable_t          PRESETS     = DEFAULT_PRESETS,
  parameter logic [SEL_W-1:0]      SEL_DEFAULT = '1
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic              outEnableIn,
  input  logic [SEL_W-1:0]  presetSel,
  output ctrlStrobe_t       strobe
);
  localparam int MIN_HALF = MIN_RATIO / 2;

  logic [SEL_W-1:0]        selMeta;
  logic [SEL_W-1:0]        selSync;
  chanCfg_t [NUM_OUT-1:0]  cfgNext;
  chanCfg_t [NUM_OUT-1:0]  cfgQ;
  chanCfg_t [NUM_OUT-1:0]  cfgReset;

  // Two-flop select synchroniser, resets to the pulled-up value
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      selMeta <= SEL_DEFAULT;
      selSync <= SEL_DEFAULT;
    end else begin
      selMeta <= presetSel;
      selSync <= selMeta;
    end
  end

  always_comb begin
    for (int ch = 0; ch < NUM_OUT; ch++) begin
      cfgNext[ch]  = screenField(PRESETS[selSync][ch]);
      cfgReset[ch] = screenField(PRESETS[SEL_DEFAULT][ch]);
    end
  end

  // Registered table lookup keeps the screen off the divider path
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) cfgQ <= cfgReset;
    else       cfgQ <= cfgNext;
  end

  always_comb begin
    strobe.halt = !outEnableIn;
    strobe.cfg  = cfgQ;
  end

  for (genvar ch = 0; ch < NUM_OUT; ch++) begin : g_chk
    // R4: a configuration marked valid never carries a half below the minimum
    assert_cfg_half_legal_R4 : assert property (@(posedge refClk) disable iff (!rstN)
      cfgQ[ch].valid |-> (cfgQ[ch].half >= HALF_W'(MIN_HALF)));
  end
endmodule

// File: rtl/pdd_divider.sv
module pdd_divider
  import pdd_pkg::*;
(
  input  logic      refClk,
  input  logic      rstN,
  input  logic      halt,
  input  chanCfg_t  cfg,
  output logic      clkOut,
  output logic      oeOut
);
  logic              running;
  logic [HALF_W-1:0] half;
  logic [HALF_W-1:0] cnt;
  logic              lastCnt;
  logic              periodEnd;

  assign lastCnt   = (cnt == half - 1'b1);
  assign periodEnd = lastCnt && !clkOut;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      half    <= '0;
      cnt     <= '0;
      clkOut  <= 1'b0;
      oeOut   <= 1'b0;
    end else if (halt) begin
      running <= 1'b0;
      cnt     <= '0;
      clkOut  <= 1'b0;
      oeOut   <= 1'b0;
    end else begin
      oeOut <= 1'b1;
      if (!running || periodEnd) begin
        // boundary: adopt whatever configuration is current
        running <= cfg.valid;
        half    <= cfg.half;
        cnt     <= '0;
        clkOut  <= cfg.valid;
      end else if (lastCnt) begin
        cnt    <= '0;
        clkOut <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5: a halt clears the clock and the drive enable on the next edge
  assert_halt_silences_R5 : assert property (@(posedge refClk) disable iff (!rstN)
    halt |=> (!clkOut && !oeOut));

  // R3: the phase counter stays below the active half length
  assert_count_bound_R3 : assert property (@(posedge refClk) disable iff (!rstN)
    running |-> (cnt < half));

  // R7: the clock level only moves at the end of a phase
  assert_phase_hold_R7 : assert property (@(posedge refClk) disable iff (!rstN)
    (running && !halt && !lastCnt) |=> $stable(clkOut));

  // R4: a running divider always holds a legal half length
  assert_running_half_R4 : assert property (@(posedge refClk) disable iff (!rstN)
    running |-> (half >= HALF_W'(MIN_RATIO / 2)));
endmodule

// File: rtl/preset_dual_divider.sv
module preset_dual_divider
  import pdd_pkg::*;
#(
  parameter presetTable_t     PRESETS     = DEFAULT_PRESETS,
  parameter logic [SEL_W-1:0] SEL_DEFAULT = '1
) (
  input  logic               refClk,
  input  logic               rstN,
  input  logic               outEnableIn,
  input  logic [SEL_W-1:0]   presetSel,
  output logic [NUM_OUT-1:0] divClk,
  output logic [NUM_OUT-1:0] divOe
);
  ctrlStrobe_t strobe;

  pdd_ctrl #(
    .PRESETS     (PRESETS),
    .SEL_DEFAULT (SEL_DEFAULT)
  ) u_ctrl (
    .refClk      (refClk),
    .rstN        (rstN),
    .outEnableIn (outEnableIn),
    .presetSel   (presetSel),
    .strobe      (strobe)
  );

  for (genvar ch = 0; ch < NUM_OUT; ch++) begin : g_chan
    pdd_divider u_div (
      .refClk (refClk),
      .rstN   (rstN),
      .halt   (strobe.halt),
      .cfg    (strobe.cfg[ch]),
      .clkOut (divClk[ch]),
      .oeOut  (divOe[ch])
    );
  end

  // R6: both drive enables always move together
  assert_oe_together_R6 : assert property (@(posedge refClk) disable iff (!rstN)
    (divOe == '0) || (divOe == '1));
endmodule

// File: tb/tb_preset_dual_divider.sv
module tb_preset_dual_divider;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       refClk = 1'b0;
  logic       rstN = 1'b0;
  logic       outEnableIn = 1'b1;
  logic [2:0] presetSel = 3'd0;
  logic [1:0] divClk;
  logic [1:0] divOe;

  int checks = 0;
  int errors = 0;
  int phaseLen[16];
  int phaseVal[16];

  // Independent copy of the preset table: [select][output]
  int expEn[8][2];
  int expRatio[8][2];

  preset_dual_divider dut (
    .refClk(refClk), .rstN(rstN), .outEnableIn(outEnableIn),
    .presetSel(presetSel), .divClk(divClk), .divOe(divOe)
  );

  always #(CLK_PERIOD/2) refClk = ~refClk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int isValid(input int s, input int ch);
    int r = expRatio[s][ch];
    return (expEn[s][ch] != 0 && r % 2 == 0 && r >= 4 && r <= 254) ? 1 : 0;
  endfunction

  // Records n complete phases of output ch, starting at a rising edge
  task automatic capture(input int ch, input int n, output int ok);
    logic prev, cur;
    int guard, len, idx;
    ok = 1; guard = 0;
    @(negedge refClk); prev = divClk[ch];
    forever begin
      @(negedge refClk); cur = divClk[ch];
      if (!prev && cur) break;
      prev = cur; guard++;
      if (guard > 2000) begin ok = 0; return; end
    end
    prev = cur; len = 1; idx = 0;
    while (idx < n) begin
      @(negedge refClk); cur = divClk[ch];
      if (cur == prev) len++;
      else begin
        phaseLen[idx] = len; phaseVal[idx] = int'(prev);
        idx++; len = 1;
      end
      prev = cur; guard++;
      if (guard > 4000) begin ok = 0; return; end
    end
  endtask

  task automatic transitionCheck(input int ch, input int oldHalf, input int newHalf);
    int ok, seenNew, bad;
    capture(ch, 12, ok);
    check("R7 capture completes", ok, 1);
    seenNew = 0; bad = 0;
    for (int i = 0; i < 12; i++) begin
      if (phaseLen[i] != oldHalf && phaseLen[i] != newHalf) bad++;
      if (phaseLen[i] == newHalf) seenNew = 1;
      else if (seenNew) bad++;
      if (i % 2 == 0 && phaseLen[i] != phaseLen[i+1]) bad++;
    end
    check("R7 no runt or mid-period reload", bad, 0);
    check("R7 new ratio reached", phaseLen[11], newHalf);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++; checks++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hiLen[2];
    int done[2];
    int ok, seenHigh, oeBad;

    expEn[0] = '{1, 1}; expRatio[0] = '{10, 8};
    expEn[1] = '{0, 1}; expRatio[1] = '{20, 12};
    expEn[2] = '{1, 1}; expRatio[2] = '{6, 9};
    expEn[3] = '{1, 1}; expRatio[3] = '{2, 254};
    expEn[4] = '{1, 1}; expRatio[4] = '{254, 4};
    expEn[5] = '{0, 0}; expRatio[5] = '{16, 16};
    expEn[6] = '{1, 1}; expRatio[6] = '{255, 14};
    expEn[7] = '{1, 1}; expRatio[7] = '{8, 10};

    // R1: reset state
    repeat (5) @(negedge refClk);
    check("R1 clocks in reset", int'(divClk), 0);
    check("R1 drive enables in reset", int'(divOe), 0);

    // R8: select held at 0, first period follows preset 7
    rstN = 1'b1;
    hiLen = '{0, 0}; done = '{0, 0};
    for (int k = 0; k < 14; k++) begin
      @(negedge refClk);
      for (int ch = 0; ch < 2; ch++)
        if (!done[ch]) begin
          if (divClk[ch]) hiLen[ch]++;
          else if (hiLen[ch] > 0) done[ch] = 1;
        end
    end
    check("R8 first high phase output 0", hiLen[0], expRatio[7][0] / 2);
    check("R8 first high phase output 1", hiLen[1], expRatio[7][1] / 2);

    // R2/R3/R4: sweep every preset
    for (int s = 0; s < 8; s++) begin
      @(negedge refClk); presetSel = 3'(s);
      repeat (300) @(negedge refClk);
      for (int ch = 0; ch < 2; ch++) begin
        if (isValid(s, ch) != 0) begin
          capture(ch, 4, ok);
          check($sformatf("R2 sel %0d out %0d running", s, ch), ok, 1);
          check($sformatf("R2 sel %0d out %0d period", s, ch),
                phaseLen[0] + phaseLen[1], expRatio[s][ch]);
          check($sformatf("R3 sel %0d out %0d high", s, ch), phaseLen[2], expRatio[s][ch] / 2);
          check($sformatf("R3 sel %0d out %0d low", s, ch), phaseLen[3], expRatio[s][ch] / 2);
        end else begin
          seenHigh = 0; oeBad = 0;
          for (int k = 0; k < 300; k++) begin
            @(negedge refClk);
            if (divClk[ch]) seenHigh++;
            if (!divOe[ch]) oeBad++;
          end
          check($sformatf("R4 sel %0d out %0d held low", s, ch), seenHigh, 0);
          check($sformatf("R4 sel %0d out %0d still driven", s, ch), oeBad, 0);
        end
      end
    end

    // R7: switch 7 -> 0 swaps the half lengths 4 <-> 5
    @(negedge refClk); presetSel = 3'd7;
    repeat (300) @(negedge refClk);
    presetSel = 3'd0;
    transitionCheck(0, expRatio[7][0] / 2, expRatio[0][0] / 2);
    @(negedge refClk); presetSel = 3'd7;
    repeat (300) @(negedge refClk);
    presetSel = 3'd0;
    transitionCheck(1, expRatio[7][1] / 2, expRatio[0][1] / 2);

    // R5: enable low silences both outputs by the next edge
    @(negedge refClk); presetSel = 3'd7;
    repeat (300) @(negedge refClk);
    outEnableIn = 1'b0;
    @(negedge refClk);
    check("R5 clocks low after one edge", int'(divClk), 0);
    check("R5 drive enables low", int'(divOe), 0);
    seenHigh = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge refClk);
      if (divClk != 2'b00 || divOe != 2'b00) seenHigh++;
    end
    check("R5 outputs stay silent", seenHigh, 0);

    // R6: reassert, both outputs rise on the same edge
    outEnableIn = 1'b1;
    @(negedge refClk);
    check("R6 both clocks start high together", int'(divClk), 3);
    check("R6 drive enables restored", int'(divOe), 3);
    hiLen = '{1, 1}; done = '{0, 0};
    for (int k = 0; k < 12; k++) begin
      @(negedge refClk);
      for (int ch = 0; ch < 2; ch++)
        if (!done[ch]) begin
          if (divClk[ch]) hiLen[ch]++;
          else done[ch] = 1;
        end
    end
    check("R6 restart phase output 0", hiLen[0], expRatio[7][0] / 2);
    check("R6 restart phase output 1", hiLen[1], expRatio[7][1] / 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule